// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block sequences single external memory accesses over an 8-bit bus that carries both the low address byte and the data byte, plus a separate 8-bit port for the high address byte. An internal requester presents a 16-bit address, a flag that selects program space or data space, a write flag and a write byte. The block then runs a fixed sequence. First a latch-enable pulse tells an external latch to capture the low address. After a one-cycle gap, one active-low strobe runs: the program strobe for code fetches, or the read or write strobe for data space. The block ends with a one-cycle completion pulse that returns the read byte.

One clock cycle stands for one oscillator half-period. The latch pulse lasts 3 cycles and each strobe lasts 4 cycles. A slow device holds READY low to stretch the strobe one cycle at a time. While reset is asserted, a float-select pin decides how the control outputs behave. If it is high, the outputs are driven to their inactive-high level. If it is low, their output enable is released so that they float.

The requester holds its request until it sees the completion pulse. A request that is still present in the idle cycle after completion starts a new access.

Top module: `ebc_bus`

## Requirements
- R1: Access timing starts at the clock edge that accepts a request. For the next 3 cycles, `ale` is high, `ad_oe` is 1 and `ad_o` equals the low address byte. After that, `ale` stays low until the next access.
- R2: `hi_addr` equals address bits 15..8 from the first latch cycle through the completion cycle.
- R3: A code access (`req_code`=1) drives `psen_n` low for 4 cycles. The strobe starts in the second cycle after `ale` falls, so there is exactly one gap cycle. `rd_n` and `wr_n` stay high. `req_wr` is ignored, and a code access is always a read.
- R4: A data access (`req_code`=0) uses the same timing as R3. It drives `rd_n` low when `req_wr`=0 and `wr_n` low when `req_wr`=1. Only one strobe is low at any time.
- R5: `ready` is sampled at the edge that would end the strobe. Each such edge that sees `ready`=0 lengthens the strobe by one cycle.
- R6: During a write, `ad_oe` is 1 and `ad_o` equals the write byte from the first strobe cycle through the cycle after the strobe ends. During a read, `ad_oe` is 0 from the end of the latch pulse through completion. When idle, `ad_oe` is 0.
- R7: A read captures `ad_i` at the edge where the strobe returns high. `rdata` holds that byte until the next read capture, and a write does not change it.
- R8: `done` is high for exactly one cycle, the cycle right after the strobe rises.
- R9: While `rst_n` is low, `ctl_oe` equals `float_sel`. When `ctl_oe` is 1 in that state, `ale`, `psen_n`, `rd_n` and `wr_n` are all 1. After reset, `ctl_oe` is 1, `ale` is 0, the three strobes are 1, `ad_oe` is 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one period per oscillator half-period |
| rst_n | input | 1 | Asynchronous active-low reset |
| float_sel | input | 1 | During reset: 1 drives the controls high, 0 floats them |
| req | input | 1 | Access request, held until done |
| req_addr | input | 16 | Access address |
| req_code | input | 1 | 1 selects program space, 0 selects data space |
| req_wr | input | 1 | Write flag for data space |
| req_wdata | input | 8 | Write byte |
| ready | input | 1 | Low to insert wait cycles |
| ad_i | input | 8 | Multiplexed bus input |
| ad_o | output | 8 | Multiplexed bus output value |
| ad_oe | output | 1 | Multiplexed bus output enable |
| hi_addr | output | 8 | High address byte |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ctl_oe | output | 1 | Output enable for ale and the three strobes |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last byte read |

## Verification
Cycle t is counted from the edge that accepts the request, starting at 0. The latch pulse covers cycles 0 to 2 and the gap is cycle 3. The strobe covers cycles 4 to 7+W, where W is the number of low READY samples, and `done` with the new `rdata` falls in cycle 8+W. The bench drives `ready` at each falling edge from the same index, so the sample point at the end of cycle 7 is under its control. It compares every pin against a per-cycle expectation at the falling edge, away from the edge that moves the outputs. One further idle cycle after each access checks that the bus and `done` have returned to rest.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [2:0] {S_IDLE, S_ALE, S_GAP, S_STB, S_END} ebc_st_e;

  // a code fetch is always a read
  function automatic logic eff_write(input logic code, input logic wr);
    return wr & ~code;
  endfunction

  // last planned strobe cycle: where READY is looked at
  function automatic logic at_last(input int unsigned cnt, input int unsigned width);
    return cnt == width - 1;
  endfunction
endpackage

// File: rtl/ebc_seq.sv
module ebc_seq import ebc_pkg::*; #(
  parameter int ADW   = 8,
  parameter int ALE_W = 3,
  parameter int STB_W = 4,
  localparam int AW   = 2 * ADW,
  localparam int MAXW = (ALE_W > STB_W) ? ALE_W : STB_W,
  localparam int CW   = $clog2(MAXW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic [AW-1:0]  req_addr,
  input  logic           req_code,
  input  logic           req_wr,
  input  logic [ADW-1:0] req_wdata,
  input  logic           ready,
  input  logic [ADW-1:0] ad_i,
  output ebc_st_e        st,
  output logic [AW-1:0]  addr_q,
  output logic           code_q,
  output logic           wr_q,
  output logic [ADW-1:0] wdata_q,
  output logic [ADW-1:0] rdata,
  output logic           ready_sample,
  output logic           strobe_end
);
  logic [CW-1:0] cnt;

  assign ready_sample = (st == S_STB) && at_last(cnt, STB_W);
  assign strobe_end   = ready_sample && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      code_q  <= 1'b0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata   <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (req) begin
          addr_q  <= req_addr;
          code_q  <= req_code;
          wr_q    <= eff_write(req_code, req_wr);
          wdata_q <= req_wdata;
          cnt     <= '0;
          st      <= S_ALE;
        end
        S_ALE: begin
          if (at_last(cnt, ALE_W)) begin
            cnt <= '0;
            st  <= S_GAP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_GAP: begin
          cnt <= '0;
          st  <= S_STB;
        end
        S_STB: begin
          if (strobe_end) begin
            st <= S_END;
            if (!wr_q) rdata <= ad_i;
          end else if (!ready_sample) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_END: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ebc_pins.sv
module ebc_pins import ebc_pkg::*; #(
  parameter int ADW = 8,
  localparam int AW = 2 * ADW
) (
  input  logic           rst_n,
  input  logic           float_sel,
  input  ebc_st_e        st,
  input  logic [AW-1:0]  addr_q,
  input  logic           code_q,
  input  logic           wr_q,
  input  logic [ADW-1:0] wdata_q,
  output logic [ADW-1:0] ad_o,
  output logic           ad_oe,
  output logic [ADW-1:0] hi_addr,
  output logic           ale,
  output logic           psen_n,
  output logic           rd_n,
  output logic           wr_n,
  output logic           ctl_oe,
  output logic           done
);
  logic in_ale, in_stb, in_end;

  assign in_ale = (st == S_ALE);
  assign in_stb = (st == S_STB);
  assign in_end = (st == S_END);

  always_comb begin
    ctl_oe  = rst_n | float_sel;
    hi_addr = addr_q[AW-1:ADW];
    done    = in_end;
    ad_o    = in_ale ? addr_q[ADW-1:0] : wdata_q;
    ad_oe   = in_ale | (wr_q & (in_stb | in_end));
    if (!rst_n) begin
      ale    = 1'b1;
      psen_n = 1'b1;
      rd_n   = 1'b1;
      wr_n   = 1'b1;
    end else begin
      ale    = in_ale;
      psen_n = ~(in_stb & code_q);
      rd_n   = ~(in_stb & ~code_q & ~wr_q);
      wr_n   = ~(in_stb & wr_q);
    end
  end
endmodule

// File: rtl/ebc_bus.sv
module ebc_bus import ebc_pkg::*; #(
  parameter int ADW   = 8,
  parameter int ALE_W = 3,
  parameter int STB_W = 4,
  localparam int AW   = 2 * ADW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           float_sel,
  input  logic           req,
  input  logic [AW-1:0]  req_addr,
  input  logic           req_code,
  input  logic           req_wr,
  input  logic [ADW-1:0] req_wdata,
  input  logic           ready,
  input  logic [ADW-1:0] ad_i,
  output logic [ADW-1:0] ad_o,
  output logic           ad_oe,
  output logic [ADW-1:0] hi_addr,
  output logic           ale,
  output logic           psen_n,
  output logic           rd_n,
  output logic           wr_n,
  output logic           ctl_oe,
  output logic           done,
  output logic [ADW-1:0] rdata
);
  ebc_st_e        st;
  logic [AW-1:0]  addr_q;
  logic           code_q, wr_q;
  logic [ADW-1:0] wdata_q;
  logic           ready_sample, strobe_end;

  ebc_seq #(.ADW(ADW), .ALE_W(ALE_W), .STB_W(STB_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
    .req_code(req_code), .req_wr(req_wr), .req_wdata(req_wdata),
    .ready(ready), .ad_i(ad_i), .st(st), .addr_q(addr_q),
    .code_q(code_q), .wr_q(wr_q), .wdata_q(wdata_q), .rdata(rdata),
    .ready_sample(ready_sample), .strobe_end(strobe_end)
  );

  ebc_pins #(.ADW(ADW)) u_pins (
    .rst_n(rst_n), .float_sel(float_sel), .st(st), .addr_q(addr_q),
    .code_q(code_q), .wr_q(wr_q), .wdata_q(wdata_q), .ad_o(ad_o),
    .ad_oe(ad_oe), .hi_addr(hi_addr), .ale(ale), .psen_n(psen_n),
    .rd_n(rd_n), .wr_n(wr_n), .ctl_oe(ctl_oe), .done(done)
  );
endmodule

// File: rtl/ebc_chk.sv
module ebc_chk #(
  parameter int ALE_W = 3
) (
  input logic clk,
  input logic rst_n,
  input logic float_sel,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic ctl_oe,
  input logic ad_oe,
  input logic done,
  input logic ready,
  input logic ready_sample,
  input logic strobe_end
);
  logic        up;
  logic [15:0] ale_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up      <= 1'b0;
      ale_run <= '0;
    end else begin
      up      <= 1'b1;
      ale_run <= ale ? ale_run + 16'd1 : 16'd0;
    end
  end

  // R1: latch pulse length
  assert_ale_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (up && $fell(ale)) |-> (ale_run == 16'(ALE_W)));

  // R4: never two strobes at once, never a strobe under the latch pulse
  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({~psen_n, ~rd_n, ~wr_n}) <= 1) && !(ale && !(psen_n && rd_n && wr_n)));

  // R5: a low READY at the sample point keeps the strobe low
  assert_ready_stretch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_sample && !ready) |=> !(psen_n && rd_n && wr_n));

  // R8: completion follows strobe end, and lasts one cycle
  assert_done_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_end |=> done);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: bus released whenever no access is underway
  assert_bus_rest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !ale && psen_n && rd_n && wr_n && !done) |-> (!ad_oe || $past(ale)) || !$past(psen_n && rd_n && wr_n) || ad_oe == 1'b0 || $past(ad_oe));

  // R9: driven controls are inactive during reset
  always_comb begin
    if (!rst_n && ctl_oe && !$isunknown(float_sel))
      assert_rst_level_R9: assert (ale && psen_n && rd_n && wr_n);
  end
endmodule

bind ebc_bus ebc_chk #(.ALE_W(ALE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .float_sel(float_sel), .ale(ale),
  .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .ctl_oe(ctl_oe),
  .ad_oe(ad_oe), .done(done), .ready(ready),
  .ready_sample(ready_sample), .strobe_end(strobe_end)
);

// File: tb/sim_ebc_bus.sv
module sim_ebc_bus;
  logic clk = 1'b0;
  logic rst_n, float_sel, req, req_code, req_wr, ready;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata, ad_i;
  logic [7:0]  ad_o, hi_addr, rdata;
  logic        ad_oe, ale, psen_n, rd_n, wr_n, ctl_oe, done;
  int errors = 0;
  int checks = 0;
  logic [7:0] last_rd = 8'h00;

  always #5 clk = ~clk;

  ebc_bus u0 (
    .clk(clk), .rst_n(rst_n), .float_sel(float_sel), .req(req),
    .req_addr(req_addr), .req_code(req_code), .req_wr(req_wr),
    .req_wdata(req_wdata), .ready(ready), .ad_i(ad_i), .ad_o(ad_o),
    .ad_oe(ad_oe), .hi_addr(hi_addr), .ale(ale), .psen_n(psen_n),
    .rd_n(rd_n), .wr_n(wr_n), .ctl_oe(ctl_oe), .done(done), .rdata(rdata)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // expected strobe vector {psen_n, rd_n, wr_n} for cycle t
  function automatic logic [2:0] exp_stb(input int t, input int w, input logic code, input logic wr);
    logic on;
    on = (t >= 4) && (t <= 7 + w);
    if (!on) return 3'b111;
    if (code) return 3'b011;
    return wr ? 3'b110 : 3'b101;
  endfunction

  task automatic access(input logic code, input logic wr, input logic [15:0] addr,
                        input logic [7:0] wd, input logic [7:0] rv, input int w);
    logic ew;
    ew = wr & ~code;
    @(negedge clk);
    req = 1'b1; req_code = code; req_wr = wr; req_addr = addr;
    req_wdata = wd; ad_i = rv; ready = 1'b0;
    for (int t = 0; t <= 8 + w; t++) begin
      @(negedge clk);
      ready = (t >= 7 + w);
      check("R1 ale", 16'(ale), 16'(t < 3));
      check("R2 hi_addr", 16'(hi_addr), 16'(addr[15:8]));
      if (code) check("R3 strobes", 16'({psen_n, rd_n, wr_n}), 16'(exp_stb(t, w, code, wr)));
      else      check("R4 strobes", 16'({psen_n, rd_n, wr_n}), 16'(exp_stb(t, w, code, wr)));
      if (w > 0 && t == 7 + w) check("R5 stretched strobe", 16'(psen_n & rd_n & wr_n), 16'd0);
      check("R6 ad_oe", 16'(ad_oe), 16'((t < 3) || (ew && t >= 4)));
      if (t < 3) check("R1 low address", 16'(ad_o), 16'(addr[7:0]));
      else if (ew && t >= 4) check("R6 write data", 16'(ad_o), 16'(wd));
      check("R8 done", 16'(done), 16'(t == 8 + w));
      if (t == 8 + w) begin
        if (!ew) last_rd = rv;
        check("R7 rdata", 16'(rdata), 16'(last_rd));
        req = 1'b0;
        ad_i = ~rv;
      end
    end
    @(negedge clk);
    check("R8 done low after", 16'(done), 16'd0);
    check("R6 idle bus", 16'(ad_oe), 16'd0);
    check("R7 rdata held", 16'(rdata), 16'(last_rd));
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    rst_n = 1'b0; float_sel = 1'b1; req = 1'b0; req_code = 1'b0; req_wr = 1'b0;
    req_addr = '0; req_wdata = '0; ready = 1'b1; ad_i = '0;
    #12;
    check("R9 driven oe", 16'(ctl_oe), 16'd1);
    check("R9 driven levels", 16'({ale, psen_n, rd_n, wr_n}), 16'hF);
    float_sel = 1'b0;
    #3;
    check("R9 float oe", 16'(ctl_oe), 16'd0);
    float_sel = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset", 16'({ctl_oe, ale, psen_n, rd_n, wr_n, ad_oe, done}), 16'b1011100);
    check("R7 rdata reset", 16'(rdata), 16'h00);
    // directed corners
    access(1'b1, 1'b0, 16'h1234, 8'h00, 8'hA5, 0);  // code fetch
    access(1'b0, 1'b0, 16'hBEEF, 8'h00, 8'h3C, 0);  // data read
    access(1'b0, 1'b1, 16'h00FF, 8'h5A, 8'hEE, 0);  // data write
    access(1'b1, 1'b1, 16'hFF00, 8'h77, 8'h81, 0);  // code with write flag: R3 read
    access(1'b0, 1'b0, 16'h4321, 8'h00, 8'hC3, 1);  // R5 one wait
    access(1'b0, 1'b1, 16'h8001, 8'h99, 8'h11, 3);  // R5 waits on write
    access(1'b1, 1'b0, 16'h7FFF, 8'h00, 8'h42, 5);
    // random mix
    for (int i = 0; i < 60; i++) begin
      access(1'($urandom), 1'($urandom), 16'($urandom), 8'($urandom),
             8'($urandom), int'($urandom % 4));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule